// File: doc/BRIEF.md
# PCI Parity Guard

This block produces the even parity bit for every cycle in which the device drives the shared address/data lines. It also checks the parity that other agents return for address and data phases. A mismatch is judged by the device's role and by whether it was the addressed target. A mismatch that counts raises a one-cycle error pulse and a sticky status flag. When the mismatch hits a data phase of the device's own master transfer, the block also requests an abort and blocks all later master cycles until reset.

In its master role the block also watches the system-error line at a fixed distance after its own address phase. A hit there requests immediate termination of the transfer, so control goes back to the local side. The block sits between the bus pins and the master/target state machines. Those machines supply the phase markers and the role, and they act on the abort and inhibit outputs.

Top module: `pcipar_guard`

## Requirements
- R1: In the cycle after a clock edge that samples `drive_ad` high, `par_oe` is 1 and `par_out` equals the XOR of all bits of `ad_in` and `cbe_in` from that edge. This makes the total count of ones, parity bit included, even. After an edge that samples `drive_ad` low, `par_oe` is 0.
- R2: Parity is judged against `par_in` sampled one edge after the phase edge. A phase is an edge with `addr_phase` or `data_phase` high, and `addr_phase` wins if both are high. `par_in` is compared with the XOR of the `ad_in`/`cbe_in` values from the phase edge. The error outputs change only at that second edge.
- R3: An address-phase mismatch counts when `is_master` was 0, whatever `selected` was. An address phase with `is_master` 1 is not checked.
- R4: A data-phase mismatch with `is_master` 0 counts only when `selected` was 1.
- R5: A data-phase mismatch with `is_master` 1 counts whatever `selected` was.
- R6: A counted error drives `perr_out` high for exactly one cycle and sets `perr_status` at the same edge. A good phase, or a mismatch that does not count, leaves both low.
- R7: `perr_status` stays set until an edge samples `stat_w1c` high with no new error. If a new error and `stat_w1c` meet at the same edge, the set wins.
- R8: A counted master data-phase error pulses `abort_req` for one cycle alongside `perr_out`. It also sets `master_inhibit`, which stays 1 until reset, whatever follows.
- R9: After an edge that samples `addr_phase` high with `is_master` 1, `serr_in` high at the second edge after it pulses `abort_req` for one cycle. This does not touch `perr_out`, `perr_status` or `master_inhibit`.
- R10: `serr_in` at any other distance from a master address phase, or after a slave address phase, leaves `abort_req` low.
- R11: Errors counted in the slave role never raise `abort_req` or `master_inhibit`.
- R12: While `rst_n` is low, `par_out`, `par_oe`, `perr_out`, `perr_status`, `abort_req` and `master_inhibit` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus clock |
| rst_n | input | 1 | asynchronous reset, active low |
| ad_in | input | 32 | address/data lines as seen on the bus |
| cbe_in | input | 4 | command/byte-enable lines as seen on the bus |
| par_in | input | 1 | parity line as seen on the bus |
| drive_ad | input | 1 | device drives address/data this cycle |
| is_master | input | 1 | 1 = device is bus master, 0 = target |
| selected | input | 1 | device is the addressed target |
| addr_phase | input | 1 | this cycle is an address phase |
| data_phase | input | 1 | this cycle completes a data phase |
| serr_in | input | 1 | system error seen (active high) |
| stat_w1c | input | 1 | write-one-to-clear strobe for the status flag |
| par_out | output | 1 | generated even parity |
| par_oe | output | 1 | enable for driving the parity line |
| perr_out | output | 1 | one-cycle parity error pulse (active high) |
| perr_status | output | 1 | sticky parity error flag |
| abort_req | output | 1 | request to end the current master transfer |
| master_inhibit | output | 1 | blocks master cycles until reset |

## Verification
The assertions check on every cycle that generated parity follows the sampled bus one cycle later, and that the parity enable tracks the drive request. They also check that every error pulse comes with a set status flag, that the flag holds without a clear strobe, and that the inhibit flag never drops and only rises together with an abort and an error pulse. The role and selection matrix needs the bench's scenarios: which mismatches count, the exact cycle of each pulse, set-over-clear priority, and the single SERR offset that aborts.

// File: rtl/pcipar_pkg.sv
package pcipar_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADR  = 2'd1,
        PH_DAT  = 2'd2
    } phase_e;

    // phase captured at the bus edge, judged one edge later
    typedef struct packed {
        phase_e ph;
        logic   mst;
        logic   sel;
        logic   exp_par;
    } cap_t;

    // error handler state
    typedef struct packed {
        logic perr;
        logic stat;
        logic abort;
        logic inhib;
    } err_t;

endpackage

// File: rtl/pcipar_gen.sv
module pcipar_gen #(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  ad,
    input  logic [CBE_W-1:0] cbe,
    input  logic             drive,
    output logic             par,
    output logic             oe
);
    typedef struct packed {
        logic par;
        logic oe;
    } gen_t;

    gen_t gen_d, gen_q;

    always_comb begin
        gen_d     = gen_q;
        gen_d.oe  = drive;
        gen_d.par = drive ? ^{ad, cbe} : gen_q.par;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign par = gen_q.par;
    assign oe  = gen_q.oe;
endmodule

// File: rtl/pcipar_chk.sv
module pcipar_chk
    import pcipar_pkg::*;
#(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  ad,
    input  logic [CBE_W-1:0] cbe,
    input  logic             par_in,
    input  logic             addr_phase,
    input  logic             data_phase,
    input  logic             is_master,
    input  logic             selected,
    output logic             flag,
    output logic             mst_data_err
);
    cap_t cap_d, cap_q;
    logic mismatch, adr_err, dat_err_s, dat_err_m;

    always_comb begin
        cap_d.ph      = addr_phase ? PH_ADR : (data_phase ? PH_DAT : PH_IDLE);
        cap_d.mst     = is_master;
        cap_d.sel     = selected;
        cap_d.exp_par = ^{ad, cbe};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '{ph: PH_IDLE, mst: 1'b0, sel: 1'b0, exp_par: 1'b0};
        else        cap_q <= cap_d;
    end

    // parity for the captured phase arrives one clock later
    always_comb begin
        mismatch  = (cap_q.ph != PH_IDLE) && (par_in != cap_q.exp_par);
        adr_err   = mismatch && (cap_q.ph == PH_ADR) && !cap_q.mst;
        dat_err_s = mismatch && (cap_q.ph == PH_DAT) && !cap_q.mst && cap_q.sel;
        dat_err_m = mismatch && (cap_q.ph == PH_DAT) && cap_q.mst;
    end

    assign flag         = adr_err | dat_err_s | dat_err_m;
    assign mst_data_err = dat_err_m;
endmodule

// File: rtl/pcipar_serr.sv
module pcipar_serr #(
    parameter int LAG = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic serr_in,
    output logic hit
);
    logic [LAG-1:0] sh_d, sh_q;

    generate
        if (LAG == 1) begin : g_one
            always_comb sh_d = start;
        end else begin : g_many
            always_comb sh_d = {sh_q[LAG-2:0], start};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign hit = sh_q[LAG-1] & serr_in;
endmodule

// File: rtl/pcipar_err.sv
module pcipar_err
    import pcipar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flag,
    input  logic mst_data_err,
    input  logic serr_hit,
    input  logic w1c,
    output logic perr,
    output logic stat,
    output logic abort,
    output logic inhib
);
    err_t err_d, err_q;

    always_comb begin
        err_d.perr  = flag;
        err_d.stat  = flag | (err_q.stat & ~w1c);
        err_d.abort = mst_data_err | serr_hit;
        err_d.inhib = err_q.inhib | mst_data_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    assign perr  = err_q.perr;
    assign stat  = err_q.stat;
    assign abort = err_q.abort;
    assign inhib = err_q.inhib;
endmodule

// File: rtl/pcipar_guard.sv
module pcipar_guard #(
    parameter int AD_W     = 32,
    parameter int CBE_W    = 4,
    parameter int SERR_LAG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  ad_in,
    input  logic [CBE_W-1:0] cbe_in,
    input  logic             par_in,
    input  logic             drive_ad,
    input  logic             is_master,
    input  logic             selected,
    input  logic             addr_phase,
    input  logic             data_phase,
    input  logic             serr_in,
    input  logic             stat_w1c,
    output logic             par_out,
    output logic             par_oe,
    output logic             perr_out,
    output logic             perr_status,
    output logic             abort_req,
    output logic             master_inhibit
);
    logic flag, mst_data_err, serr_hit;

    pcipar_gen #(.AD_W(AD_W), .CBE_W(CBE_W)) u_gen (
        .clk(clk), .rst_n(rst_n), .ad(ad_in), .cbe(cbe_in),
        .drive(drive_ad), .par(par_out), .oe(par_oe)
    );

    pcipar_chk #(.AD_W(AD_W), .CBE_W(CBE_W)) u_chk (
        .clk(clk), .rst_n(rst_n), .ad(ad_in), .cbe(cbe_in), .par_in(par_in),
        .addr_phase(addr_phase), .data_phase(data_phase),
        .is_master(is_master), .selected(selected),
        .flag(flag), .mst_data_err(mst_data_err)
    );

    pcipar_serr #(.LAG(SERR_LAG)) u_serr (
        .clk(clk), .rst_n(rst_n), .start(addr_phase & is_master),
        .serr_in(serr_in), .hit(serr_hit)
    );

    pcipar_err u_err (
        .clk(clk), .rst_n(rst_n), .flag(flag), .mst_data_err(mst_data_err),
        .serr_hit(serr_hit), .w1c(stat_w1c),
        .perr(perr_out), .stat(perr_status), .abort(abort_req), .inhib(master_inhibit)
    );
endmodule

// File: rtl/pcipar_guard_chk.sv
module pcipar_guard_chk #(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AD_W-1:0]  ad_in,
    input logic [CBE_W-1:0] cbe_in,
    input logic             drive_ad,
    input logic             addr_phase,
    input logic             data_phase,
    input logic             stat_w1c,
    input logic             par_out,
    input logic             par_oe,
    input logic             perr_out,
    input logic             perr_status,
    input logic             abort_req,
    input logic             master_inhibit
);
    assert_par_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        drive_ad |=> (par_oe && (par_out == $past(^{ad_in, cbe_in}))));

    assert_oe_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_ad |=> !par_oe);

    assert_perr_needs_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        perr_out |-> $past(addr_phase || data_phase, 2));

    assert_perr_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        perr_out |-> perr_status);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_status && !stat_w1c) |=> perr_status);

    assert_inhibit_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        master_inhibit |=> master_inhibit);

    assert_inhibit_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(master_inhibit) |-> (abort_req && perr_out));
endmodule

bind pcipar_guard pcipar_guard_chk #(.AD_W(AD_W), .CBE_W(CBE_W)) u_guard_chk (
    .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .cbe_in(cbe_in),
    .drive_ad(drive_ad), .addr_phase(addr_phase), .data_phase(data_phase),
    .stat_w1c(stat_w1c), .par_out(par_out), .par_oe(par_oe),
    .perr_out(perr_out), .perr_status(perr_status),
    .abort_req(abort_req), .master_inhibit(master_inhibit)
);

// File: tb/pcipar_guard_test.sv
module pcipar_guard_test;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic        rst_n;
    logic [31:0] ad_in;
    logic [3:0]  cbe_in;
    logic par_in, drive_ad, is_master, selected, addr_phase, data_phase, serr_in, stat_w1c;
    logic par_out, par_oe, perr_out, perr_status, abort_req, master_inhibit;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    pcipar_guard uut (
        .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .cbe_in(cbe_in), .par_in(par_in),
        .drive_ad(drive_ad), .is_master(is_master), .selected(selected),
        .addr_phase(addr_phase), .data_phase(data_phase), .serr_in(serr_in),
        .stat_w1c(stat_w1c), .par_out(par_out), .par_oe(par_oe), .perr_out(perr_out),
        .perr_status(perr_status), .abort_req(abort_req), .master_inhibit(master_inhibit)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        drive_ad = 0; addr_phase = 0; data_phase = 0; serr_in = 0; stat_w1c = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; idle(); par_in = 0; is_master = 0; selected = 0;
        ad_in = '0; cbe_in = '0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    // one phase, judged by role and selection (R2..R8, R11)
    task automatic run_phase(bit mst, bit sel, bit dat, bit badp, logic [31:0] a, logic [3:0] c);
        bit flag, mabort;
        flag   = badp && (dat ? (mst || sel) : !mst);
        mabort = flag && mst && dat;
        do_reset();
        is_master = mst; selected = sel; ad_in = a; cbe_in = c;
        addr_phase = !dat; data_phase = dat;
        @(negedge clk);
        idle(); ad_in = ~a; par_in = (^{a, c}) ^ badp;
        @(negedge clk);
        chk("R6 perr pulse R3 R4 R5", perr_out, flag);
        chk("R6 flag set", perr_status, flag);
        chk("R8 abort R11", abort_req, mabort);
        chk("R8 inhibit R11", master_inhibit, mabort);
        @(negedge clk);
        chk("R6 perr one cycle", perr_out, 0);
        chk("R7 flag sticky", perr_status, flag);
        chk("R8 inhibit held", master_inhibit, mabort);
        stat_w1c = 1;
        @(negedge clk);
        stat_w1c = 0;
        chk("R7 w1c clears", perr_status, 0);
    endtask

    task automatic serr_try(bit mst, int off);
        do_reset();
        is_master = mst; ad_in = 32'h1234_5678; cbe_in = 4'h6;
        addr_phase = 1;
        @(negedge clk);
        idle(); par_in = ^{32'h1234_5678, 4'h6};
        for (int k = 1; k <= 4; k++) begin
            serr_in = (k == off);
            @(negedge clk);
            chk(mst && off == 2 ? "R9 serr abort" : "R10 serr ignored",
                abort_req, (mst && off == 2 && k == 2));
        end
        idle();
        chk("R9 no perr", perr_out, 0);
        chk("R9 no flag", perr_status, 0);
        chk("R9 no inhibit", master_inhibit, 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R12 act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; idle(); par_in = 0; is_master = 0; selected = 0; ad_in = '0; cbe_in = '0;
        @(negedge clk);
        chk("R12 par_out", par_out, 0);
        chk("R12 par_oe", par_oe, 0);
        chk("R12 perr", perr_out, 0);
        chk("R12 flag", perr_status, 0);
        chk("R12 abort", abort_req, 0);
        chk("R12 inhibit", master_inhibit, 0);
        do_reset();

        // parity generation sweep
        for (int c = 0; c < 16; c++) begin
            for (int p = 0; p < 4; p++) begin
                logic [31:0] a;
                a = 32'hA5C3_0F01 ^ (32'h1111_1111 * p) ^ (32'(c) << (p * 7));
                drive_ad = 1; ad_in = a; cbe_in = 4'(c);
                @(negedge clk);
                chk("R1 parity", {par_oe, par_out}, {1'b1, ^{a, 4'(c)}});
            end
        end
        drive_ad = 0; ad_in = 32'hFFFF_FFFF;
        @(negedge clk);
        chk("R1 oe off", par_oe, 0);

        // role x selection x phase x parity
        for (int i = 0; i < 32; i++) begin
            run_phase(i[0], i[1], i[2], i[3], i[4] ? 32'hFFFF_FFFF : 32'h0000_8001, 4'(i * 3));
        end

        // set wins over clear (R7)
        do_reset();
        is_master = 0; selected = 1; ad_in = 32'h0F0F_0003; cbe_in = 4'h1; data_phase = 1;
        @(negedge clk);
        idle(); par_in = ~(^{32'h0F0F_0003, 4'h1}); stat_w1c = 1;
        @(negedge clk);
        stat_w1c = 0;
        chk("R7 set beats clear", perr_status, 1);

        // inhibit persists through later activity (R8)
        do_reset();
        is_master = 1; ad_in = 32'h7; cbe_in = 4'h0; data_phase = 1;
        @(negedge clk);
        idle(); par_in = 0;
        @(negedge clk);
        chk("R8 inhibit set", master_inhibit, 1);
        is_master = 0; selected = 1;
        for (int k = 0; k < 4; k++) begin
            data_phase = 1; ad_in = 32'(k); stat_w1c = 1;
            @(negedge clk);
            idle(); par_in = ^{32'(k), 4'h0};
            @(negedge clk);
        end
        chk("R8 inhibit kept", master_inhibit, 1);
        chk("R11 no abort", abort_req, 0);
        do_reset();
        @(negedge clk);
        chk("R12 inhibit cleared", master_inhibit, 0);

        // SERR window
        serr_try(1, 1);
        serr_try(1, 2);
        serr_try(1, 3);
        serr_try(0, 2);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule